// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory device from power-up to its ready state by driving the command bus through the mandatory start-up order. After reset it keeps the clock enable and the termination enable low while the supply and clock settle. It then raises the clock enable and issues a fixed series of commands: a precharge of all banks, writes to the four mode registers (DLL on, DLL reset), a second precharge-all, a configurable number of auto-refreshes, a second main-mode write that clears the DLL reset bit, and the pair of extended-mode writes that enter and then leave the default output-driver calibration state.

The integrator supplies the operating values for the main mode register and for extended mode registers 1, 2 and 3. The sequencer forces only the bits the start-up order controls: the DLL enable, the DLL reset and the calibration field. It passes all other bits through. Spacing between commands, refresh spacing, the settle time, the lead time after the clock enable rises and the minimum wait from the second precharge-all to calibration entry are all parameters. When the last write has been given its spacing time, `init_done` rises. A memory controller then takes over the bus.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low and for the first SETTLE_CYCLES rising clock edges after it is released, `ddr_cke` is 0 and the bus carries NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1). `ddr_cke` is 1 after edge SETTLE_CYCLES and stays 1.
- R2: `ddr_odt` is 0 on every cycle.
- R3: Commands appear in this order: precharge-all, EMR2 write, EMR3 write, EMR1 write, MR write, precharge-all, NUM_REF refreshes, MR write, EMR1 write, EMR1 write. The register is selected by `ddr_ba`: MR=0, EMR1=1, EMR2=2, EMR3=3.
- R4: A precharge-all is `cs_n,ras_n,cas_n,we_n` = 0,0,1,0 with `ddr_addr` bit 10 = 1, all other address bits 0 and `ddr_ba`=0. A refresh is 0,0,0,1 with address and bank 0. A mode write is 0,0,0,0.
- R5: The first command appears CKE_LEAD cycles after `ddr_cke` rises. Each following command comes CMD_GAP cycles after the one before it, or REF_GAP cycles after a refresh, except where R8 delays it.
- R6: The first MR write carries `mr_val` with bit 8 (DLL reset) forced to 1. The second carries `mr_val` with bit 8 forced to 0.
- R7: Every EMR1 write carries `emr1_val` with bit 0 forced to 0 (DLL enabled). Bits 9:7 are 3'b111 on the calibration-entry write and 3'b000 on the other two EMR1 writes.
- R8: The calibration-entry EMR1 write comes no earlier than OCD_WAIT cycles after the second precharge-all. Its cycle is the later of that bound and CMD_GAP after the preceding MR write.
- R9: Exactly NUM_REF refresh commands are issued.
- R10: `init_done` rises CMD_GAP cycles after the final EMR1 write and stays high. The bus then carries only NOP.
- R11: The EMR2 and EMR3 writes carry `emr2_val` and `emr3_val` unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mr_val | input | ADDR_W | Operating value for the main mode register |
| emr1_val | input | ADDR_W | Operating value for extended mode register 1 |
| emr2_val | input | ADDR_W | Value for extended mode register 2 |
| emr3_val | input | ADDR_W | Value for extended mode register 3 |
| ddr_cke | output | 1 | Clock enable to the memory |
| ddr_odt | output | 1 | On-die termination enable, held low |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank / mode register select |
| ddr_addr | output | ADDR_W | Address / mode register value |
| init_done | output | 1 | High once the start-up order is complete |

## Verification
The assertions check, on every cycle, the invariants that do not depend on position in the sequence. A low clock enable always comes with NOP. The clock enable never falls once raised. Every precharge carries the all-banks bit. Commands are never adjacent when the spacings are at least two. The calibration-entry write never precedes the end of its wait window. Completion is sticky, and the bus stays idle after completion. The exact order of the commands, the cycle of each command, and the forcing and pass-through of individual mode bits are shown only by the bench scenarios. Those scenarios run two parameter sets (one where the calibration wait dominates, one where the command spacing dominates) against several mode-value patterns, including all-ones and all-zeros.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  // Command codes as {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  // Mode register select on the bank pins
  localparam logic [1:0] SEL_MR   = 2'd0;
  localparam logic [1:0] SEL_EMR1 = 2'd1;
  localparam logic [1:0] SEL_EMR2 = 2'd2;
  localparam logic [1:0] SEL_EMR3 = 2'd3;

  // Address bit positions the sequence controls
  localparam int BIT_DLL_OFF = 0;
  localparam int BIT_OCD_LO  = 7;
  localparam int BIT_DLL_RST = 8;
  localparam int BIT_OCD_HI  = 9;
  localparam int BIT_ALLBANK = 10;

  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_RUN    = 2'd1,
    PH_DONE   = 2'd2
  } init_phase_e;

endpackage

// File: rtl/ddr2_init_down_cnt.sv
module ddr2_init_down_cnt #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (load_en) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  // R5: an expired window stays expired until reloaded
  p_hold_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && zero) |=> zero);

endmodule

// File: rtl/ddr2_init_cmd_dec.sv
module ddr2_init_cmd_dec #(
  parameter int NUM_REF = 2,
  parameter int ADDR_W  = 13,
  parameter int STEP_W  = 4
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] mr_val,
  input  logic [ADDR_W-1:0] emr1_val,
  input  logic [ADDR_W-1:0] emr2_val,
  input  logic [ADDR_W-1:0] emr3_val,
  output logic [3:0]        cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              is_ref,
  output logic              is_prea2,
  output logic              is_ocd_on
);
  import ddr2_init_pkg::*;

  localparam logic [STEP_W-1:0] ST_PREA0  = STEP_W'(0);
  localparam logic [STEP_W-1:0] ST_EMR2   = STEP_W'(1);
  localparam logic [STEP_W-1:0] ST_EMR3   = STEP_W'(2);
  localparam logic [STEP_W-1:0] ST_EMR1   = STEP_W'(3);
  localparam logic [STEP_W-1:0] ST_MRRST  = STEP_W'(4);
  localparam logic [STEP_W-1:0] ST_PREA1  = STEP_W'(5);
  localparam logic [STEP_W-1:0] ST_REF0   = STEP_W'(6);
  localparam logic [STEP_W-1:0] ST_MRRUN  = STEP_W'(6 + NUM_REF);
  localparam logic [STEP_W-1:0] ST_OCDON  = STEP_W'(7 + NUM_REF);
  localparam logic [STEP_W-1:0] ST_OCDOFF = STEP_W'(8 + NUM_REF);

  logic [ADDR_W-1:0] emr1_base;
  logic [ADDR_W-1:0] prea_addr;

  always_comb begin
    emr1_base                        = emr1_val;
    emr1_base[BIT_DLL_OFF]           = 1'b0;
    emr1_base[BIT_OCD_HI:BIT_OCD_LO] = 3'b000;
    prea_addr                        = '0;
    prea_addr[BIT_ALLBANK]           = 1'b1;
  end

  assign is_ref    = (step >= ST_REF0) && (step < ST_MRRUN);
  assign is_prea2  = (step == ST_PREA1);
  assign is_ocd_on = (step == ST_OCDON);

  always_comb begin
    cmd  = CMD_NOP;
    ba   = SEL_MR;
    addr = '0;
    if (step == ST_PREA0 || step == ST_PREA1) begin
      cmd  = CMD_PRE;
      addr = prea_addr;
    end else if (is_ref) begin
      cmd  = CMD_REF;
    end else if (step == ST_EMR2) begin
      cmd  = CMD_MRS;
      ba   = SEL_EMR2;
      addr = emr2_val;
    end else if (step == ST_EMR3) begin
      cmd  = CMD_MRS;
      ba   = SEL_EMR3;
      addr = emr3_val;
    end else if (step == ST_EMR1 || step == ST_OCDOFF) begin
      cmd  = CMD_MRS;
      ba   = SEL_EMR1;
      addr = emr1_base;
    end else if (step == ST_OCDON) begin
      cmd  = CMD_MRS;
      ba   = SEL_EMR1;
      addr = emr1_base;
      addr[BIT_OCD_HI:BIT_OCD_LO] = 3'b111;
    end else if (step == ST_MRRST) begin
      cmd  = CMD_MRS;
      ba   = SEL_MR;
      addr = mr_val;
      addr[BIT_DLL_RST] = 1'b1;
    end else if (step == ST_MRRUN) begin
      cmd  = CMD_MRS;
      ba   = SEL_MR;
      addr = mr_val;
      addr[BIT_DLL_RST] = 1'b0;
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq #(
  parameter int SETTLE_CYCLES = 20,
  parameter int CKE_LEAD      = 4,
  parameter int CMD_GAP       = 2,
  parameter int REF_GAP       = 6,
  parameter int NUM_REF       = 2,
  parameter int OCD_WAIT      = 200,
  parameter int ADDR_W        = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mr_val,
  input  logic [ADDR_W-1:0] emr1_val,
  input  logic [ADDR_W-1:0] emr2_val,
  input  logic [ADDR_W-1:0] emr3_val,
  output logic              ddr_cke,
  output logic              ddr_odt,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [1:0]        ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);
  import ddr2_init_pkg::*;

  localparam int N_STEP = 9 + NUM_REF;
  localparam int STEP_W = $clog2(N_STEP + 1);
  localparam int CNT_W  = $clog2(SETTLE_CYCLES + CKE_LEAD + CMD_GAP + REF_GAP + 1);
  localparam int OCD_W  = $clog2(OCD_WAIT + 1);
  localparam logic [STEP_W-1:0] ST_END = STEP_W'(N_STEP);

  init_phase_e       phase_q, phase_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              cke_q, cke_d;
  logic [3:0]        cmd_q, cmd_d;
  logic [1:0]        ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;

  logic              gap_load;
  logic [CNT_W-1:0]  gap_val;
  logic              gap_zero;
  logic              ocd_load;
  logic              ocd_zero;

  logic [3:0]        dec_cmd;
  logic [1:0]        dec_ba;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_ref;
  logic              dec_prea2;
  logic              dec_ocd_on;

  ddr2_init_cmd_dec #(
    .NUM_REF (NUM_REF),
    .ADDR_W  (ADDR_W),
    .STEP_W  (STEP_W)
  ) u_dec (
    .step      (step_q),
    .mr_val    (mr_val),
    .emr1_val  (emr1_val),
    .emr2_val  (emr2_val),
    .emr3_val  (emr3_val),
    .cmd       (dec_cmd),
    .ba        (dec_ba),
    .addr      (dec_addr),
    .is_ref    (dec_ref),
    .is_prea2  (dec_prea2),
    .is_ocd_on (dec_ocd_on)
  );

  // Shared spacing counter: settle window, CKE lead, then command gaps
  ddr2_init_down_cnt #(
    .W       (CNT_W),
    .RST_VAL (CNT_W'(SETTLE_CYCLES - 1))
  ) u_gap_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (gap_load),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  // Minimum wait from second precharge-all to calibration entry
  ddr2_init_down_cnt #(
    .W       (OCD_W),
    .RST_VAL ('0)
  ) u_ocd_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (ocd_load),
    .load_val (OCD_W'(OCD_WAIT - 1)),
    .zero     (ocd_zero)
  );

  always_comb begin
    phase_d  = phase_q;
    step_d   = step_q;
    step_en  = 1'b0;
    cke_d    = cke_q;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    done_d   = done_q;
    gap_load = 1'b0;
    gap_val  = '0;
    ocd_load = 1'b0;
    case (phase_q)
      PH_SETTLE: begin
        if (gap_zero) begin
          phase_d  = PH_RUN;
          cke_d    = 1'b1;
          gap_load = 1'b1;
          gap_val  = CNT_W'(CKE_LEAD - 1);
        end
      end
      PH_RUN: begin
        if (gap_zero) begin
          if (step_q == ST_END) begin
            phase_d = PH_DONE;
            done_d  = 1'b1;
          end else if (!dec_ocd_on || ocd_zero) begin
            cmd_d    = dec_cmd;
            ba_d     = dec_ba;
            addr_d   = dec_addr;
            gap_load = 1'b1;
            gap_val  = dec_ref ? CNT_W'(REF_GAP - 1) : CNT_W'(CMD_GAP - 1);
            ocd_load = dec_prea2;
            step_en  = 1'b1;
            step_d   = step_q + STEP_W'(1);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SETTLE;
      step_q  <= '0;
      cke_q   <= 1'b0;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (step_en) begin
        step_q <= step_d;
      end
      cke_q  <= cke_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign ddr_cke   = cke_q;
  assign ddr_odt   = 1'b0;
  assign ddr_cs_n  = cmd_q[3];
  assign ddr_ras_n = cmd_q[2];
  assign ddr_cas_n = cmd_q[1];
  assign ddr_we_n  = cmd_q[0];
  assign ddr_ba    = ba_q;
  assign ddr_addr  = addr_q;
  assign init_done = done_q;

  // R1: no command while the clock enable is low
  p_nop_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |-> (cmd_q == CMD_NOP));

  // R1: clock enable never drops once raised
  p_cke_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cke_q |=> cke_q);

  // R4: every precharge targets all banks
  p_prea_allbank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> addr_q[BIT_ALLBANK]);

  // R5: with spacings of two or more, commands never sit back to back
  if (CMD_GAP >= 2 && REF_GAP >= 2) begin : g_gap_chk
    p_cmd_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));
  end

  // R8: calibration entry only after the wait window has run out
  p_ocd_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS && ba_q == SEL_EMR1 &&
     addr_q[BIT_OCD_HI:BIT_OCD_LO] == 3'b111) |-> ocd_zero);

  // R10: completion is sticky and the bus is idle afterwards
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cmd_q == CMD_NOP && cke_q));

endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_env #(
  parameter int SETTLE_CYCLES = 20,
  parameter int CKE_LEAD      = 4,
  parameter int CMD_GAP       = 2,
  parameter int REF_GAP       = 6,
  parameter int NUM_REF       = 2,
  parameter int OCD_WAIT      = 200,
  parameter int ADDR_W        = 13,
  parameter int RUNS          = 4
) (
  input logic clk
);
  localparam int N_STEP   = 9 + NUM_REF;
  localparam int S_PREA1  = 5;
  localparam int S_MRRUN  = 6 + NUM_REF;
  localparam int S_OCDON  = 7 + NUM_REF;
  localparam int S_OCDOFF = 8 + NUM_REF;
  localparam int LIMIT    = SETTLE_CYCLES + CKE_LEAD + N_STEP * (CMD_GAP + REF_GAP) + OCD_WAIT + 50;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] MRS = 4'b0000;

  logic              rst_n;
  logic [ADDR_W-1:0] mr_v, e1_v, e2_v, e3_v;
  logic              cke, odt, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]        ba;
  logic [ADDR_W-1:0] addr;

  int n_chk;
  int n_fail;
  bit fin;

  int                got_t [32];
  logic [3:0]        got_c [32];
  logic [1:0]        got_b [32];
  logic [ADDR_W-1:0] got_a [32];
  int                exp_t [32];

  ddr2_init_seq #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .CKE_LEAD      (CKE_LEAD),
    .CMD_GAP       (CMD_GAP),
    .REF_GAP       (REF_GAP),
    .NUM_REF       (NUM_REF),
    .OCD_WAIT      (OCD_WAIT),
    .ADDR_W        (ADDR_W)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mr_val    (mr_v),
    .emr1_val  (e1_v),
    .emr2_val  (e2_v),
    .emr3_val  (e3_v),
    .ddr_cke   (cke),
    .ddr_odt   (odt),
    .ddr_cs_n  (cs_n),
    .ddr_ras_n (ras_n),
    .ddr_cas_n (cas_n),
    .ddr_we_n  (we_n),
    .ddr_ba    (ba),
    .ddr_addr  (addr),
    .init_done (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] e_cmd(input int s);
    if (s == 0 || s == S_PREA1) return PRE;
    if (s >= 6 && s < S_MRRUN) return REF;
    return MRS;
  endfunction

  function automatic logic [1:0] e_ba(input int s);
    if (s == 1) return 2'd2;
    if (s == 2) return 2'd3;
    if (s == 3 || s == S_OCDON || s == S_OCDOFF) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [ADDR_W-1:0] e_addr(input int s);
    logic [ADDR_W-1:0] v;
    v = '0;
    if (s == 0 || s == S_PREA1) begin
      v[10] = 1'b1;
    end else if (s == 1) begin
      v = e2_v;
    end else if (s == 2) begin
      v = e3_v;
    end else if (s == 3 || s == S_OCDON || s == S_OCDOFF) begin
      v = e1_v;
      v[0] = 1'b0;
      v[9:7] = (s == S_OCDON) ? 3'b111 : 3'b000;
    end else if (s == 4) begin
      v = mr_v;
      v[8] = 1'b1;
    end else if (s == S_MRRUN) begin
      v = mr_v;
      v[8] = 1'b0;
    end
    return v;
  endfunction

  function automatic string req_of(input int s);
    if (s == 0 || s == S_PREA1) return "R4";
    if (s == 1 || s == 2) return "R11";
    if (s == 4 || s == S_MRRUN) return "R6";
    if (s >= 6 && s < S_MRRUN) return "R9";
    return "R7";
  endfunction

  task automatic run(input int idx);
    int   n_got, cke_t, done_t, bad_odt, bad_low, cke_drop, done_drop, n_ref, order_bad, t, tp, exp_done;
    logic [3:0] c;
    if (idx == 0) begin
      mr_v = '1; e1_v = '1; e2_v = '1; e3_v = '1;
    end else if (idx == 1) begin
      mr_v = '0; e1_v = '0; e2_v = '0; e3_v = '0;
    end else begin
      mr_v = ADDR_W'(idx * 32'h1A5F + 32'h0123);
      e1_v = ADDR_W'(idx * 32'h0B3D + 32'h0481);
      e2_v = ADDR_W'(idx * 32'h0975 + 32'h0066);
      e3_v = ADDR_W'(idx * 32'h1C29 + 32'h0F0F);
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(cke == 1'b0 && odt == 1'b0 && done == 1'b0, "R1", "reset cke/odt/done",
        {29'd0, cke, odt, done}, 32'd0);
    chk({cs_n, ras_n, cas_n, we_n} == NOP, "R1", "reset bus NOP",
        {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, NOP});
    rst_n = 1'b1;
    n_got = 0; cke_t = -1; done_t = -1; bad_odt = 0; bad_low = 0;
    cke_drop = 0; done_drop = 0; n_ref = 0;
    for (int k = 1; k <= LIMIT; k++) begin
      @(posedge clk);
      @(negedge clk);
      c = {cs_n, ras_n, cas_n, we_n};
      if (odt) bad_odt++;
      if (!cke && c != NOP) bad_low++;
      if (cke_t < 0 && cke) cke_t = k;
      if (cke_t >= 0 && !cke) cke_drop++;
      if (c != NOP) begin
        if (n_got < 32) begin
          got_t[n_got] = k; got_c[n_got] = c; got_b[n_got] = ba; got_a[n_got] = addr;
        end
        if (c == REF) n_ref++;
        n_got++;
      end
      if (done_t < 0 && done) done_t = k;
      if (done_t >= 0 && (!done || c != NOP)) done_drop++;
      if (done_t >= 0 && k >= done_t + 8) break;
    end
    // expected issue cycles
    t = SETTLE_CYCLES + CKE_LEAD;
    tp = 0;
    for (int s = 0; s < N_STEP; s++) begin
      if (s == S_OCDON && tp + OCD_WAIT > t) t = tp + OCD_WAIT;
      exp_t[s] = t;
      if (s == S_PREA1) tp = t;
      t = t + ((s >= 6 && s < S_MRRUN) ? REF_GAP : CMD_GAP);
    end
    exp_done = exp_t[N_STEP-1] + CMD_GAP;

    chk(cke_t == SETTLE_CYCLES, "R1", "cke rise cycle", cke_t, SETTLE_CYCLES);
    chk(bad_low == 0 && cke_drop == 0, "R1", "nop while cke low / cke held",
        bad_low + cke_drop, 0);
    chk(bad_odt == 0, "R2", "odt high cycles", bad_odt, 0);
    chk(n_got == N_STEP, "R3", "command count", n_got, N_STEP);
    chk(n_ref == NUM_REF, "R9", "refresh count", n_ref, NUM_REF);
    if (n_got == N_STEP) begin
      order_bad = 0;
      for (int s = 0; s < N_STEP; s++) begin
        if (got_c[s] != e_cmd(s) || got_b[s] != e_ba(s)) order_bad++;
      end
      chk(order_bad == 0, "R3", "order mismatches", order_bad, 0);
      for (int s = 0; s < N_STEP; s++) begin
        chk(got_c[s] == e_cmd(s), "R4", $sformatf("step %0d code", s), got_c[s], e_cmd(s));
        chk(got_b[s] == e_ba(s), "R3", $sformatf("step %0d bank", s), got_b[s], e_ba(s));
        chk(got_a[s] == e_addr(s), req_of(s), $sformatf("step %0d addr", s),
            32'(got_a[s]), 32'(e_addr(s)));
        chk(got_t[s] == exp_t[s], (s == S_OCDON) ? "R8" : "R5",
            $sformatf("step %0d cycle", s), got_t[s], exp_t[s]);
      end
    end
    chk(done_t == exp_done, "R10", "done rise cycle", done_t, exp_done);
    chk(done_drop == 0, "R10", "done sticky, bus idle", done_drop, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    mr_v = '0; e1_v = '0; e2_v = '0; e3_v = '0;
    n_chk = 0; n_fail = 0; fin = 1'b0;
    for (int r = 0; r < RUNS; r++) begin
      run(r);
    end
    fin = 1'b1;
  end

endmodule

module ddr2_init_seq_tb;
  logic clk;
  int   checks;
  int   failures;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Calibration wait dominates the spacing before entry
  ddr2_init_seq_env #(
    .SETTLE_CYCLES (12), .CKE_LEAD (4), .CMD_GAP (2), .REF_GAP (5),
    .NUM_REF (2), .OCD_WAIT (200), .ADDR_W (13), .RUNS (4)
  ) u_env_a (.clk (clk));

  // Command spacing dominates; three refreshes
  ddr2_init_seq_env #(
    .SETTLE_CYCLES (7), .CKE_LEAD (3), .CMD_GAP (3), .REF_GAP (4),
    .NUM_REF (3), .OCD_WAIT (10), .ADDR_W (13), .RUNS (4)
  ) u_env_b (.clk (clk));

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (u_env_a.fin && u_env_b.fin) break;
      if (cyc == 99999) timed_out = 1'b1;
    end
    checks   = u_env_a.n_chk + u_env_b.n_chk;
    failures = u_env_a.n_fail + u_env_b.n_fail;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog: act=running exp=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule